// File: doc/BRIEF.md
# Load/Store Effective Address Generator

This block turns the operand fields of a load or store into a memory access description. It adds a base register value, an optional index register shifted by a small scale, and a sign-extended 16-bit displacement. From the sum it derives the byte lanes that the access size covers, using either little-endian or big-endian lane numbering. It flags any access that is not aligned to its natural size. In the autoupdate mode it also hands the computed address back as a write to the base register.

A request is captured on a rising clock edge, and every result appears together one cycle later. The base write-back port is meant to feed a register file write port directly. It carries the register index that came with the request and the same address that was sent to memory.

Top module: `ls_addr_gen`

## Requirements
- R1: With `req_mode` = 2'b00 (displacement), `ea` equals `base_val` plus `disp` sign-extended from 16 bits, modulo 2^32. `index_val` and `scale_code` have no effect on `ea`.
- R2: With `req_mode` = 2'b01 (scaled index), `ea` equals `base_val` + `index_val` × 2^`scale_code` + sign-extended `disp`. Scale codes 0, 1, 2 and 3 give factors 1, 2, 4 and 8.
- R3: With `req_mode` = 2'b10 (autoupdate), `ea` is formed as in R1. If the access is aligned, `wb_en` is 1 in the same cycle as `ea_valid`, `wb_idx` equals the request's `base_idx`, and `wb_data` equals `ea`.
- R4: `req_mode` = 2'b11 forms `ea` as in R1 and never asserts `wb_en`. Modes 2'b00 and 2'b01 never assert `wb_en` either.
- R5: `misaligned` is 1 for a halfword (`req_size` = 2'b01) whose `ea[0]` is 1, and for a word (`req_size` = 2'b10 or 2'b11) whose `ea[1:0]` is not 0. A byte (`req_size` = 2'b00) is never misaligned.
- R6: With `big_endian` = 0, lane i of `lane_en` serves byte address offset i (`ea[1:0]`). A byte enables lane `ea[1:0]`, a halfword enables lanes `ea[1:0]` and `ea[1:0]`+1, and a word enables all four lanes.
- R7: With `big_endian` = 1, the lane pattern of R6 is mirrored: the lane that R6 would give as i becomes lane 3−i.
- R8: A misaligned access has `lane_en` = 4'b0000 and `wb_en` = 0, in every mode including autoupdate.
- R9: Results appear on the clock edge after the one that accepts a request with `req_valid` = 1. After an edge that sees `req_valid` = 0, `ea_valid`, `lane_en`, `misaligned` and `wb_en` are all 0.
- R10: While `rst_n` is 0, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_mode | input | 2 | Addressing mode: 00 displacement, 01 scaled index, 10 autoupdate, 11 displacement without write-back |
| req_size | input | 2 | Access size: 00 byte, 01 halfword, 10/11 word |
| big_endian | input | 1 | 1 selects mirrored (big-endian) lane numbering |
| base_val | input | 32 | Base register value |
| base_idx | input | 5 | Base register number, returned on the write-back port |
| index_val | input | 32 | Index register value (scaled mode only) |
| scale_code | input | 2 | Index scale as a power of two |
| disp | input | 16 | Signed displacement |
| ea_valid | output | 1 | Result valid |
| ea | output | 32 | Effective address |
| lane_en | output | 4 | Byte lane enables |
| misaligned | output | 1 | Access not aligned to its size |
| wb_en | output | 1 | Base register write-back enable |
| wb_idx | output | 5 | Base register number to write |
| wb_data | output | 32 | Updated base value |

## Verification
Base write-back and the misalignment flag can both apply to one request. An autoupdate whose sum lands off its natural boundary must report the fault and suppress both the lanes and the register update in the same result cycle. The bench provokes this collision with directed autoupdate halfword and word requests at odd and half-word offsets, and many more turn up in a long random run whose low address bits are deliberately left unconstrained. A behavioural model judges each result cycle field by field against R3, R5 and R8 together. It also checks that aligned autoupdates in neighbouring cycles still write back.

// File: rtl/lsag_pkg.sv
package lsag_pkg;
   timeunit 1ns;
   timeprecision 1ps;

   typedef enum logic [1:0] {
      AM_DISP   = 2'b00,
      AM_SCALED = 2'b01,
      AM_UPDATE = 2'b10,
      AM_PLAIN  = 2'b11
   } amode_e;

   typedef enum logic [1:0] {
      SZ_BYTE = 2'b00,
      SZ_HALF = 2'b01,
      SZ_WORD = 2'b10,
      SZ_WRSV = 2'b11
   } asize_e;
endpackage

// File: rtl/lsag_sum.sv
module lsag_sum #(
   parameter int ADDR_W    = 32,
   parameter int DISP_W    = 16,
   parameter int SCALE_W   = 2,
   parameter bit HAS_INDEX = 1'b1
) (
   input  logic [ADDR_W-1:0]  base_val,
   input  logic [ADDR_W-1:0]  index_val,
   input  logic [SCALE_W-1:0] scale_code,
   input  logic [DISP_W-1:0]  disp,
   input  logic               use_index,
   output logic [ADDR_W-1:0]  sum
);
   timeunit 1ns;
   timeprecision 1ps;

   logic [ADDR_W-1:0] disp_ext;
   logic [ADDR_W-1:0] idx_term;

   generate
      if (ADDR_W <= DISP_W) begin : g_bad_width
         $error("lsag_sum: ADDR_W must exceed DISP_W");
      end
      if (SCALE_W < 1 || SCALE_W > 3) begin : g_bad_scale
         $error("lsag_sum: SCALE_W must be 1 to 3");
      end
   endgenerate

   always_comb begin
      disp_ext = ADDR_W'(signed'(disp));
   end

   generate
      if (HAS_INDEX) begin : g_index
         always_comb begin
            idx_term = use_index ? (index_val << scale_code) : '0;
         end
      end else begin : g_no_index
         always_comb begin
            idx_term = '0;
         end
      end
   endgenerate

   always_comb begin
      sum = base_val + idx_term + disp_ext;
   end
endmodule

// File: rtl/lsag_lanes.sv
module lsag_lanes
   import lsag_pkg::*;
#(
   parameter int LANES = 4,
   localparam int OFF_W = $clog2(LANES)
) (
   input  logic [OFF_W-1:0] offset,
   input  asize_e           size,
   input  logic             big_endian,
   output logic [LANES-1:0] lane_en,
   output logic             misaligned
);
   timeunit 1ns;
   timeprecision 1ps;

   logic [OFF_W:0]    nbytes;
   logic [OFF_W-1:0]  align_mask;
   logic [LANES-1:0]  le_hit;

   generate
      if (LANES < 4 || (LANES & (LANES - 1)) != 0) begin : g_bad_lanes
         $error("lsag_lanes: LANES must be a power of two of at least 4");
      end
   endgenerate

   always_comb begin
      unique case (size)
         SZ_BYTE: nbytes = (OFF_W+1)'(1);
         SZ_HALF: nbytes = (OFF_W+1)'(2);
         default: nbytes = (OFF_W+1)'(4);
      endcase
      align_mask = OFF_W'(nbytes - 1'b1);
      misaligned = |(offset & align_mask);
   end

   generate
      for (genvar i = 0; i < LANES; i++) begin : g_hit
         localparam int unsigned LANE_ID = i;
         always_comb begin
            le_hit[i] = !misaligned
                        && (LANE_ID >= 32'(offset))
                        && (LANE_ID < (32'(offset) + 32'(nbytes)));
         end
      end
      for (genvar j = 0; j < LANES; j++) begin : g_map
         always_comb begin
            lane_en[j] = big_endian ? le_hit[LANES-1-j] : le_hit[j];
         end
      end
   endgenerate

   always_comb begin
      if (!misaligned) begin
         // R6 R7
         lane_count_chk: assert ($countones(lane_en) == int'(nbytes));
      end
   end
endmodule

// File: rtl/ls_addr_gen.sv
module ls_addr_gen
   import lsag_pkg::*;
#(
   parameter int ADDR_W    = 32,
   parameter int DISP_W    = 16,
   parameter int SCALE_W   = 2,
   parameter int REG_W     = 5,
   parameter int LANES     = 4,
   parameter bit HAS_INDEX = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req_valid,
   input  logic [1:0]         req_mode,
   input  logic [1:0]         req_size,
   input  logic               big_endian,
   input  logic [ADDR_W-1:0]  base_val,
   input  logic [REG_W-1:0]   base_idx,
   input  logic [ADDR_W-1:0]  index_val,
   input  logic [SCALE_W-1:0] scale_code,
   input  logic [DISP_W-1:0]  disp,
   output logic               ea_valid,
   output logic [ADDR_W-1:0]  ea,
   output logic [LANES-1:0]   lane_en,
   output logic               misaligned,
   output logic               wb_en,
   output logic [REG_W-1:0]   wb_idx,
   output logic [ADDR_W-1:0]  wb_data
);
   timeunit 1ns;
   timeprecision 1ps;

   localparam int OFF_W = $clog2(LANES);

   generate
      if (ADDR_W <= OFF_W) begin : g_bad_addr
         $error("ls_addr_gen: ADDR_W too small for LANES");
      end
   endgenerate

   amode_e            mode;
   asize_e            size;
   logic [ADDR_W-1:0] sum;
   logic [LANES-1:0]  lane_d;
   logic              mis_d;
   logic              wb_d;

   always_comb begin
      mode = amode_e'(req_mode);
      size = asize_e'(req_size);
   end

   lsag_sum #(
      .ADDR_W    (ADDR_W),
      .DISP_W    (DISP_W),
      .SCALE_W   (SCALE_W),
      .HAS_INDEX (HAS_INDEX)
   ) u_sum (
      .base_val   (base_val),
      .index_val  (index_val),
      .scale_code (scale_code),
      .disp       (disp),
      .use_index  (mode == AM_SCALED),
      .sum        (sum)
   );

   lsag_lanes #(
      .LANES (LANES)
   ) u_lanes (
      .offset     (sum[OFF_W-1:0]),
      .size       (size),
      .big_endian (big_endian),
      .lane_en    (lane_d),
      .misaligned (mis_d)
   );

   always_comb begin
      wb_d = req_valid && (mode == AM_UPDATE) && !mis_d;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ea_valid   <= 1'b0;
         ea         <= '0;
         lane_en    <= '0;
         misaligned <= 1'b0;
         wb_en      <= 1'b0;
         wb_idx     <= '0;
         wb_data    <= '0;
      end else begin
         ea_valid   <= req_valid;
         lane_en    <= req_valid ? lane_d : '0;
         misaligned <= req_valid && mis_d;
         wb_en      <= wb_d;
         if (req_valid) begin
            ea <= sum;
         end
         if (wb_d) begin
            wb_idx  <= base_idx;
            wb_data <= sum;
         end
      end
   end

   // R8
   mis_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      misaligned |-> (lane_en == '0 && !wb_en));

   // R3
   wb_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wb_en |-> (ea_valid && wb_data == ea));

   // R9
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ea_valid |-> (lane_en == '0 && !misaligned && !wb_en));
endmodule

// File: tb/tb_ls_addr_gen.sv
module tb_ls_addr_gen;
   timeunit 1ns;
   timeprecision 1ps;

   typedef struct {
      bit          v;
      logic [1:0]  mode;
      logic [1:0]  size;
      bit          be;
      logic [31:0] base;
      logic [4:0]  rid;
      logic [31:0] idx;
      logic [1:0]  sc;
      logic [15:0] d;
   } req_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [1:0]  req_mode = '0;
   logic [1:0]  req_size = '0;
   logic        big_endian = 1'b0;
   logic [31:0] base_val = '0;
   logic [4:0]  base_idx = '0;
   logic [31:0] index_val = '0;
   logic [1:0]  scale_code = '0;
   logic [15:0] disp = '0;
   logic        ea_valid;
   logic [31:0] ea;
   logic [3:0]  lane_en;
   logic        misaligned;
   logic        wb_en;
   logic [4:0]  wb_idx;
   logic [31:0] wb_data;

   int   n_total = 0;
   int   n_fail = 0;
   bit   done = 1'b0;
   req_t pend[$];

   always #5 clk = ~clk;

   ls_addr_gen dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_mode(req_mode),
      .req_size(req_size), .big_endian(big_endian), .base_val(base_val),
      .base_idx(base_idx), .index_val(index_val), .scale_code(scale_code),
      .disp(disp), .ea_valid(ea_valid), .ea(ea), .lane_en(lane_en),
      .misaligned(misaligned), .wb_en(wb_en), .wb_idx(wb_idx), .wb_data(wb_data)
   );

   task automatic chk(input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      n_total++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic compare(input req_t r);
      logic [31:0] e;
      logic [3:0]  le;
      logic [3:0]  lanes;
      bit          mis;
      int          off;
      string       ea_req;
      if (!r.v) begin
         chk("R9", "idle ea_valid", 64'(ea_valid), 64'd0);
         chk("R9", "idle lanes/mis/wb", {59'd0, lane_en, misaligned, wb_en}, 64'd0);
         return;
      end
      e = r.base + {{16{r.d[15]}}, r.d};
      if (r.mode == 2'b01) e = e + r.idx * (32'd1 << r.sc);
      off = int'(e[1:0]);
      case (r.size)
         2'b00: begin mis = 1'b0;         le = 4'b0001 << off; end
         2'b01: begin mis = e[0];         le = 4'b0011 << off; end
         default: begin mis = (e[1:0] != 2'b00); le = 4'b1111; end
      endcase
      lanes = 4'b0000;
      if (!mis) begin
         for (int i = 0; i < 4; i++) lanes[r.be ? 3 - i : i] = le[i];
      end
      case (r.mode)
         2'b00: ea_req = "R1";
         2'b01: ea_req = "R2";
         2'b10: ea_req = "R3";
         default: ea_req = "R4";
      endcase
      chk("R9", "ea_valid", 64'(ea_valid), 64'd1);
      chk(ea_req, "ea", 64'(ea), 64'(e));
      chk("R5", "misaligned", 64'(misaligned), 64'(mis));
      chk(mis ? "R8" : (r.be ? "R7" : "R6"), "lane_en", 64'(lane_en), 64'(lanes));
      if (r.mode == 2'b10 && !mis) begin
         chk("R3", "wb_en", 64'(wb_en), 64'd1);
         chk("R3", "wb_idx", 64'(wb_idx), 64'(r.rid));
         chk("R3", "wb_data", 64'(wb_data), 64'(e));
      end else begin
         chk(mis ? "R8" : "R4", "wb_en", 64'(wb_en), 64'd0);
      end
   endtask

   task automatic apply(input bit v, input logic [1:0] mode, input logic [1:0] size,
                        input bit be, input logic [31:0] base, input logic [4:0] rid,
                        input logic [31:0] idx, input logic [1:0] sc, input logic [15:0] d);
      req_t r;
      @(negedge clk);
      if (pend.size() > 0) compare(pend.pop_front());
      r.v = v; r.mode = mode; r.size = size; r.be = be; r.base = base;
      r.rid = rid; r.idx = idx; r.sc = sc; r.d = d;
      req_valid = v; req_mode = mode; req_size = size; big_endian = be;
      base_val = base; base_idx = rid; index_val = idx; scale_code = sc; disp = d;
      pend.push_back(r);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R10 reset state
      chk("R10", "reset outputs",
          {ea_valid, lane_en, misaligned, wb_en, wb_idx, 9'd0}, 21'd0);
      chk("R10", "reset ea", 64'(ea), 64'd0);
      chk("R10", "reset wb_data", 64'(wb_data), 64'd0);
      rst_n = 1'b1;
      // R1 negative displacement, index ignored
      apply(1, 2'b00, 2'b10, 0, 32'h0000_1000, 5'd1, 32'hDEAD_BEEF, 2'd3, 16'hFFFC);
      apply(1, 2'b00, 2'b00, 0, 32'hFFFF_FFFF, 5'd1, 32'h1234_5678, 2'd1, 16'h0002);
      // R2 every scale code
      for (int s = 0; s < 4; s++)
         apply(1, 2'b01, 2'b10, 0, 32'h0000_8000, 5'd2, 32'd3, 2'(s), 16'd8);
      apply(1, 2'b01, 2'b00, 1, 32'h0000_0100, 5'd2, 32'hFFFF_FFFF, 2'd0, 16'h8000);
      // R3 aligned autoupdate, back to back
      apply(1, 2'b10, 2'b10, 0, 32'h0000_4000, 5'd7, 32'd0, 2'd0, 16'd24);
      apply(1, 2'b10, 2'b01, 1, 32'h0000_4018, 5'd9, 32'd0, 2'd0, 16'hFFFE);
      // R4 mode 11
      apply(1, 2'b11, 2'b10, 0, 32'h0000_2000, 5'd3, 32'd5, 2'd2, 16'd4);
      // R9 idle gap
      apply(0, 2'b10, 2'b00, 0, 32'h0, 5'd4, 32'd0, 2'd0, 16'd0);
      // R5 R8 misaligned, including autoupdate collision
      apply(1, 2'b00, 2'b01, 0, 32'h0000_0001, 5'd1, 32'd0, 2'd0, 16'd0);
      apply(1, 2'b10, 2'b01, 0, 32'h0000_0010, 5'd5, 32'd0, 2'd0, 16'd3);
      apply(1, 2'b10, 2'b10, 1, 32'h0000_0010, 5'd6, 32'd0, 2'd0, 16'd2);
      apply(1, 2'b10, 2'b11, 0, 32'h0000_0013, 5'd6, 32'd0, 2'd0, 16'd0);
      apply(1, 2'b10, 2'b10, 0, 32'h0000_0013, 5'd8, 32'd0, 2'd0, 16'd1);
      // R6 R7 every byte and halfword lane, both orders
      for (int e = 0; e < 2; e++) begin
         for (int o = 0; o < 4; o++)
            apply(1, 2'b00, 2'b00, e[0], 32'h0000_0200 + 32'(o), 5'd0, 32'd0, 2'd0, 16'd0);
         apply(1, 2'b00, 2'b01, e[0], 32'h0000_0200, 5'd0, 32'd0, 2'd0, 16'd0);
         apply(1, 2'b00, 2'b01, e[0], 32'h0000_0202, 5'd0, 32'd0, 2'd0, 16'd0);
         apply(1, 2'b00, 2'b10, e[0], 32'h0000_0204, 5'd0, 32'd0, 2'd0, 16'd0);
      end
      // random mix
      for (int k = 0; k < 400; k++)
         apply(($urandom % 5) != 0, 2'($urandom), 2'($urandom), 1'($urandom),
               $urandom, 5'($urandom), $urandom, 2'($urandom), 16'($urandom));
      apply(0, 2'b00, 2'b00, 0, 32'h0, 5'd0, 32'd0, 2'd0, 16'd0);
      apply(0, 2'b00, 2'b00, 0, 32'h0, 5'd0, 32'd0, 2'd0, 16'd0);
      done = 1'b1;
      $display("%0d/%0d checks passed", n_total - n_fail, n_total);
      $finish;
   end

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         n_total++;
         n_fail++;
         $display("FAIL R9 watchdog: actual hung expected completion");
         $display("%0d/%0d checks passed", n_total - n_fail, n_total);
         $finish;
      end
   end
endmodule